// File: doc/BRIEF.md
# Window Watchdog Timer with Ratio Select

This block supervises a processor or state machine by requiring a service event in each watchdog period, neither too late nor too early. It counts strobes from a slow tick input, not core clock cycles. After it is enabled, it opens a long first window in which one service event must arrive. From then on, each period starts with a closed window, where any service is a fault, and continues with an open window, where exactly one service is expected. If the open window runs out with no service, or a service lands in a closed window, the active-low fault output is pulled low for a fixed number of ticks. The block then starts again from the long first window.

The period length comes from a base tick count, which a scale select can stretch by five. A ratio select splits each period either evenly between closed and open, or one ninth closed and eight ninths open. The service input may be asynchronous to the clock: it is synchronized, and only its rising edges count. A mode select parks the window logic when it is high, for systems that use a different supervision scheme.

Top module: `wdt_window_guard`

## Requirements
- R1: While reset is asserted, and after it is released, `faultN` is high (1 = no fault). It stays high until a window rule is broken.
- R2: When `enable` is low or `modeSel` is high, the block is idle and `faultN` is high on the next clock. This also cuts short a fault pulse in progress. When the block is armed again, it starts with the first window.
- R3: The first window after arming lasts `INIT_PERIODS` (default 8) full periods in ticks. A service event inside it ends it at once and starts a closed window.
- R4: The period P is `BASE_TICKS` ticks (default 180) with `scaleSel` = 0, and `BASE_TICKS * SCALE_MULT` ticks (five times as long) with `scaleSel` = 1.
- R5: Each regular period is a closed window followed by an open window. The closed window is P/2 ticks with `ratioSel` = 0 and P/9 ticks with `ratioSel` = 1. The open window is the rest of P.
- R6: A service event during a closed window pulls `faultN` low.
- R7: If an open window or the first window reaches its last tick with no service event, `faultN` goes low.
- R8: A fault holds `faultN` low for `FAULT_TICKS` ticks (default 16), then the first window restarts.
- R9: A service event is a 0-to-1 change of `serviceIn` after a two-flop synchronizer. It acts three clocks after the input rises. Holding `serviceIn` high counts as one event, and its fall has no effect.
- R10: Window and fault durations advance only on clocks where `tick` is 1. Clocks without a tick change no count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-clock strobe from the timebase oscillator |
| enable | input | 1 | Arms the watchdog when high |
| serviceIn | input | 1 | Service signal, may be asynchronous; rising edges count |
| scaleSel | input | 1 | 0: period = BASE_TICKS, 1: period = five times longer |
| ratioSel | input | 1 | 0: closed:open 1:1, 1: closed:open 1:8 |
| modeSel | input | 1 | 0: window checking active, 1: window logic idle |
| faultN | output | 1 | Active-low fault pulse |

## Verification
A window counter that is off by even one tick shifts every later window edge. The bench therefore places its service pulses relative to its own model's phases. A wrong closed or open length then shows within one period as a fault pulse, or a missing one, at a clock where the model disagrees. A wrong phase decode, for example treating the first window as closed, gives a fault on the very first service. A faulty synchronizer or edge detector shows either as an extra fault when a held service level crosses into a closed window, or as a shift of one clock in fault entry. Because `faultN` is compared on every clock, a divergence is reported in the cycle it first appears.

// File: rtl/wdt_win_pkg.sv
package wdt_win_pkg;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_INIT   = 3'd1,
    PH_CLOSED = 3'd2,
    PH_OPEN   = 3'd3,
    PH_FAULT  = 3'd4
  } wdtPhase_e;

  // strobes from control to datapath
  typedef struct packed {
    logic      clrCnt;
    wdtPhase_e phase;
  } wdtStrobe_t;

endpackage

// File: rtl/wdt_win_datapath.sv
module wdt_win_datapath
  import wdt_win_pkg::*;
#(
  parameter int BASE_TICKS   = 180,
  parameter int SCALE_MULT   = 5,
  parameter int INIT_PERIODS = 8,
  parameter int FAULT_TICKS  = 16,
  parameter int SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       serviceIn,
  input  logic       scaleSel,
  input  logic       ratioSel,
  input  wdtStrobe_t ctl,
  output logic       svcEdge,
  output logic       winDone
);

  localparam int PERIOD_LO = BASE_TICKS;
  localparam int PERIOD_HI = BASE_TICKS * SCALE_MULT;
  localparam int INIT_HI   = PERIOD_HI * INIT_PERIODS;
  localparam int MAX_LEN   = (INIT_HI > FAULT_TICKS) ? INIT_HI : FAULT_TICKS;
  localparam int CNT_W     = $clog2(MAX_LEN + 1);

  localparam logic [CNT_W-1:0] LEN_INIT_LO   = CNT_W'(PERIOD_LO * INIT_PERIODS);
  localparam logic [CNT_W-1:0] LEN_INIT_HI   = CNT_W'(INIT_HI);
  localparam logic [CNT_W-1:0] LEN_CL_HALF_LO  = CNT_W'(PERIOD_LO / 2);
  localparam logic [CNT_W-1:0] LEN_CL_NINTH_LO = CNT_W'(PERIOD_LO / 9);
  localparam logic [CNT_W-1:0] LEN_CL_HALF_HI  = CNT_W'(PERIOD_HI / 2);
  localparam logic [CNT_W-1:0] LEN_CL_NINTH_HI = CNT_W'(PERIOD_HI / 9);
  localparam logic [CNT_W-1:0] LEN_PER_LO    = CNT_W'(PERIOD_LO);
  localparam logic [CNT_W-1:0] LEN_PER_HI    = CNT_W'(PERIOD_HI);
  localparam logic [CNT_W-1:0] LEN_FAULT     = CNT_W'(FAULT_TICKS);

  // service synchronizer chain
  logic [SYNC_STAGES-1:0] syncQ;
  logic                   svcPrev;

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : gSync
    if (g == 0) begin : gFirst
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ[g] <= 1'b0;
        else       syncQ[g] <= serviceIn;
      end
    end else begin : gNext
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ[g] <= 1'b0;
        else       syncQ[g] <= syncQ[g-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) svcPrev <= 1'b0;
    else       svcPrev <= syncQ[SYNC_STAGES-1];
  end

  assign svcEdge = syncQ[SYNC_STAGES-1] & ~svcPrev;

  // window length for the current phase
  logic [CNT_W-1:0] periodLen;
  logic [CNT_W-1:0] closedLen;
  logic [CNT_W-1:0] curLen;

  always_comb begin
    periodLen = scaleSel ? LEN_PER_HI : LEN_PER_LO;
    if (scaleSel) closedLen = ratioSel ? LEN_CL_NINTH_HI : LEN_CL_HALF_HI;
    else          closedLen = ratioSel ? LEN_CL_NINTH_LO : LEN_CL_HALF_LO;
    case (ctl.phase)
      PH_INIT:   curLen = scaleSel ? LEN_INIT_HI : LEN_INIT_LO;
      PH_CLOSED: curLen = closedLen;
      PH_OPEN:   curLen = periodLen - closedLen;
      PH_FAULT:  curLen = LEN_FAULT;
      default:   curLen = CNT_W'(1);
    endcase
  end

  // tick counter within the current window
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           cnt <= '0;
    else if (ctl.clrCnt) cnt <= '0;
    else if (tick)       cnt <= cnt + CNT_W'(1);
  end

  assign winDone = tick && (cnt >= curLen - CNT_W'(1));

  AST_CNT_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!tick && !ctl.clrCnt) |=> $stable(cnt)); // R10

  AST_EDGE_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rstN)
    svcEdge |=> !svcEdge); // R9

endmodule

// File: rtl/wdt_win_control.sv
module wdt_win_control
  import wdt_win_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       modeSel,
  input  logic       svcEdge,
  input  logic       winDone,
  output wdtStrobe_t ctl,
  output logic       faultN
);

  wdtPhase_e state;
  wdtPhase_e stateNext;
  logic      armed;

  assign armed = enable && !modeSel;

  always_comb begin
    stateNext = state;
    if (!armed) begin
      stateNext = PH_IDLE;
    end else begin
      case (state)
        PH_IDLE: stateNext = PH_INIT;
        PH_INIT, PH_OPEN: begin
          if (svcEdge)      stateNext = PH_CLOSED;
          else if (winDone) stateNext = PH_FAULT;
        end
        PH_CLOSED: begin
          if (svcEdge)      stateNext = PH_FAULT;
          else if (winDone) stateNext = PH_OPEN;
        end
        PH_FAULT: if (winDone) stateNext = PH_INIT;
        default: stateNext = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= PH_IDLE;
    else       state <= stateNext;
  end

  assign ctl.phase  = state;
  assign ctl.clrCnt = (stateNext != state) || (state == PH_IDLE);
  assign faultN     = (state != PH_FAULT);

  AST_DISARM_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !armed |=> (state == PH_IDLE) && faultN); // R2

  AST_CLOSED_SERVICE_FAULT: assert property (@(posedge clk) disable iff (!rstN)
    (armed && state == PH_CLOSED && svcEdge) |=> !faultN); // R6

  AST_OPEN_MISS_FAULT: assert property (@(posedge clk) disable iff (!rstN)
    (armed && (state == PH_OPEN || state == PH_INIT) && winDone && !svcEdge)
      |=> !faultN); // R7

  AST_FAULT_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    (armed && state == PH_FAULT && winDone) |=> (state == PH_INIT)); // R8

  AST_SERVICE_CLOSES: assert property (@(posedge clk) disable iff (!rstN)
    (armed && (state == PH_OPEN || state == PH_INIT) && svcEdge)
      |=> (state == PH_CLOSED)); // R3

endmodule

// File: rtl/wdt_window_guard.sv
module wdt_window_guard
  import wdt_win_pkg::*;
#(
  parameter int BASE_TICKS   = 180,
  parameter int SCALE_MULT   = 5,
  parameter int INIT_PERIODS = 8,
  parameter int FAULT_TICKS  = 16
) (
  input  logic clk,
  input  logic rstN,
  input  logic tick,
  input  logic enable,
  input  logic serviceIn,
  input  logic scaleSel,
  input  logic ratioSel,
  input  logic modeSel,
  output logic faultN
);

  wdtStrobe_t ctl;
  logic       svcEdge;
  logic       winDone;

  wdt_win_datapath #(
    .BASE_TICKS  (BASE_TICKS),
    .SCALE_MULT  (SCALE_MULT),
    .INIT_PERIODS(INIT_PERIODS),
    .FAULT_TICKS (FAULT_TICKS),
    .SYNC_STAGES (2)
  ) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .tick     (tick),
    .serviceIn(serviceIn),
    .scaleSel (scaleSel),
    .ratioSel (ratioSel),
    .ctl      (ctl),
    .svcEdge  (svcEdge),
    .winDone  (winDone)
  );

  wdt_win_control uCtl (
    .clk    (clk),
    .rstN   (rstN),
    .enable (enable),
    .modeSel(modeSel),
    .svcEdge(svcEdge),
    .winDone(winDone),
    .ctl    (ctl),
    .faultN (faultN)
  );

  initial begin
    AST_BASE_SPLITS: assert (BASE_TICKS % 18 == 0); // R5
  end

endmodule

// File: tb/sim_wdt_window_guard.sv
`timescale 1ns/1ps
module sim_wdt_window_guard;

  localparam int BASE  = 180;
  localparam int SCALE = 5;
  localparam int INITP = 8;
  localparam int FTICK = 16;

  logic clk = 1'b0;
  logic rstN, tick, enable, serviceIn, scaleSel, ratioSel, modeSel;
  logic faultN;

  always #10 clk = ~clk; // 50 MHz

  wdt_window_guard #(.BASE_TICKS(BASE), .SCALE_MULT(SCALE),
                     .INIT_PERIODS(INITP), .FAULT_TICKS(FTICK)) u0 (
    .clk(clk), .rstN(rstN), .tick(tick), .enable(enable),
    .serviceIn(serviceIn), .scaleSel(scaleSel), .ratioSel(ratioSel),
    .modeSel(modeSel), .faultN(faultN));

  int nChecks = 0;
  int nFails  = 0;
  string curReq = "R1";

  task automatic check(bit ok, string req, int act, int exp, string what);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  // phases: 0 idle, 1 first window, 2 closed, 3 open, 4 fault
  int mState = 0;
  int mCnt   = 0;
  bit h1 = 0, h2 = 0, h3 = 0; // serviceIn samples of the last three clocks

  function automatic int lenOf(int st, bit sc, bit ra);
    int p, c;
    p = sc ? BASE * SCALE : BASE;
    c = ra ? p / 9 : p / 2;
    case (st)
      1: return INITP * p;
      2: return c;
      3: return p - c;
      4: return FTICK;
      default: return 1;
    endcase
  endfunction

  always @(posedge clk) begin
    bit svc, done;
    int nxt;
    if (!rstN) begin
      mState = 0; mCnt = 0; h1 = 0; h2 = 0; h3 = 0;
    end else begin
      svc  = h2 && !h3;
      done = tick && (mCnt >= lenOf(mState, scaleSel, ratioSel) - 1);
      nxt  = mState;
      if (!enable || modeSel) nxt = 0;
      else if (mState == 0) nxt = 1;
      else if (mState == 1 || mState == 3) begin
        if (svc) nxt = 2; else if (done) nxt = 4;
      end else if (mState == 2) begin
        if (svc) nxt = 4; else if (done) nxt = 3;
      end else if (mState == 4) begin
        if (done) nxt = 1;
      end
      if (nxt != mState || mState == 0) mCnt = 0;
      else if (tick) mCnt = mCnt + 1;
      mState = nxt;
      h3 = h2; h2 = h1; h1 = serviceIn;
    end
  end

  // compare on every clock, away from the active edge
  bit cmpOn = 0;
  always @(negedge clk) begin
    if (cmpOn) check(faultN === (mState != 4), curReq, int'(faultN),
                     int'(mState != 4), "faultN vs model");
  end

  // tick generator
  int tickEvery = 1;
  int tickCnt   = 0;
  always @(negedge clk) begin
    tickCnt = (tickCnt + 1) % tickEvery;
    tick = (tickCnt == 0);
  end

  task automatic cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic waitPhase(int ph);
    for (int g = 0; g < 20000 && mState != ph; g++) @(negedge clk);
  endtask

  task automatic pulseSvc(int hi);
    serviceIn = 1'b1; cycles(hi); serviceIn = 1'b0;
  endtask

  task automatic waitFault();
    for (int g = 0; g < 20000 && faultN !== 1'b0; g++) @(negedge clk);
  endtask

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog (all requirements) actual=running expected=finished");
    finishRun();
  end

  initial begin
    int lowCnt;
    rstN = 0; tick = 0; enable = 0; serviceIn = 0;
    scaleSel = 0; ratioSel = 0; modeSel = 0;
    cycles(5);
    check(faultN === 1'b1, "R1", int'(faultN), 1, "faultN in reset");
    cmpOn = 1;
    rstN = 1;
    curReq = "R1"; cycles(20);
    curReq = "R2"; cycles(20);

    // first window, 1:1 split (R3, R5)
    curReq = "R3"; enable = 1; cycles(200); pulseSvc(4);
    curReq = "R5";
    repeat (4) begin waitPhase(3); cycles(20); pulseSvc(4); end
    ratioSel = 1;
    repeat (4) begin waitPhase(3); cycles(5); pulseSvc(3); end
    check(faultN === 1'b1, "R5", int'(faultN), 1, "no fault with in-window service");

    // early service in a closed window (R6) and fault length (R8)
    curReq = "R6"; waitPhase(2); cycles(2); pulseSvc(3);
    waitFault();
    check(faultN === 1'b0, "R6", int'(faultN), 0, "closed-window service faults");
    curReq = "R8"; lowCnt = 0;
    while (faultN === 1'b0 && lowCnt < 1000) begin lowCnt++; @(negedge clk); end
    check(lowCnt == FTICK, "R8", lowCnt, FTICK, "fault pulse clocks");

    // missing service in open window (R7)
    curReq = "R7"; cycles(50); pulseSvc(3); waitPhase(3); waitFault();
    check(faultN === 1'b0, "R7", int'(faultN), 0, "missed open window faults");
    cycles(40);

    // long period (R4)
    curReq = "R4"; enable = 0; cycles(3);
    scaleSel = 1; ratioSel = 0; enable = 1;
    cycles(100); pulseSvc(3);
    repeat (3) begin waitPhase(3); cycles(30); pulseSvc(3); end

    // held service level spans into the closed window (R9)
    curReq = "R9"; waitPhase(3); cycles(10); serviceIn = 1'b1;
    cycles(600); serviceIn = 1'b0; cycles(10);
    check(faultN === 1'b1, "R9", int'(faultN), 1, "held level counts once");
    repeat (2) begin waitPhase(3); cycles(8); pulseSvc(2); end

    // mode select parks the logic (R2)
    curReq = "R2"; modeSel = 1; cycles(9000);
    check(faultN === 1'b1, "R2", int'(faultN), 1, "no fault while parked");
    modeSel = 0; cycles(100); pulseSvc(3);
    waitPhase(3); waitFault(); cycles(3);
    enable = 0; cycles(2);
    check(faultN === 1'b1, "R2", int'(faultN), 1, "disable cuts fault short");

    // sparse ticks (R10)
    curReq = "R10"; scaleSel = 0; ratioSel = 1; tickEvery = 3; enable = 1;
    cycles(100); pulseSvc(3);
    repeat (3) begin waitPhase(3); cycles(10); pulseSvc(3); end
    check(faultN === 1'b1, "R10", int'(faultN), 1, "tick-gated windows");
    waitPhase(2); cycles(4); pulseSvc(3); waitFault();
    lowCnt = 0;
    while (faultN === 1'b0 && lowCnt < 1000) begin lowCnt++; @(negedge clk); end
    check(lowCnt >= 3 * FTICK - 2 && lowCnt <= 3 * FTICK, "R10", lowCnt, 3 * FTICK,
          "fault pulse scales with tick rate");
    cycles(50);

    cmpOn = 0;
    finishRun();
  end

endmodule